// File: doc/BRIEF.md
# Receive FIFO Write-Side Manager

This block runs the write side of a receive FIFO that lives in shared frame-buffer memory. The FIFO is a run of consecutive buffer-header slots. For each received frame the block decides whether the frame belongs to the FIFO. It then issues memory write commands for the frame header, for each payload word and, at the end, for the slot status. Internally it keeps a write index and a fill level. A frame goes to the FIFO only when the current slot has no dedicated buffer and the external filter accepts it.

The header and payload of an accepted frame are written to the entry at the current write index before the frame's outcome is known. The entry is committed only when the frame turns out valid and non-null. A commit writes the status, advances the index and counts the entry. A rejected frame leaves the index where it is, so the next candidate overwrites the same slot.

The start slot, the depth and the entry size (in payload words) can be written only while the controller is in its configuration state. A pop input lets the reader lower the fill level.

Top module: `rxfifo_wr_mgr`

## Requirements
- R1: A frame whose header arrives with `frm_dedicated` high causes no memory write at all, and leaves the fill level unchanged.
- R2: A candidate frame causes no write when `frm_accept` is low or `fifo_full` is high at its header.
- R3: An appended frame's header produces one write, one cycle after `frm_hdr_vld`, with `mem_kind`=0, `mem_off`=0, `mem_wdata`=header and `mem_slot` = start slot + write index.
- R4: The payload word number n (counting from 0) of an appended frame is written one cycle after its `frm_pl_vld` with `mem_kind`=1 and `mem_off`=n, only while n < entry size. Any later words are dropped.
- R5: At `frm_end` of an appended frame with `frm_valid`=1 and `frm_null`=0, one write follows with `mem_kind`=2 and `mem_wdata`=`frm_status`. In the same cycle the write index and the fill level have each grown by one.
- R6: An appended frame that ends invalid or null produces no status write and changes neither the write index nor the fill level. The next appended frame uses the same slot.
- R7: The write index returns to 0 after a commit at index depth-1.
- R8: `fifo_full` is high exactly when the fill level equals the configured depth.
- R9: `pop_req` lowers the fill level by one when it is non-zero and does nothing at zero. A commit and a pop in the same cycle leave the fill level unchanged.
- R10: `cfg_we` loads start slot, depth and entry size only while `cfg_mode` is high. Outside that state it is ignored.
- R11: The cycle after `cfg_mode` rises, the write index and the fill level are zero. Headers arriving while `cfg_mode` is high cause no write.
- R12: After reset: `mem_we`=0, fill level 0, `fifo_full`=0, start slot 0, depth `DEF_DEPTH`, entry size `DEF_SIZE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 1 | Controller is in its configuration state |
| cfg_we | input | 1 | Load the three configuration values |
| cfg_start | input | IDX_W | First header slot of the FIFO |
| cfg_depth | input | IDX_W | Number of FIFO entries |
| cfg_size | input | OFF_W | Payload words per entry |
| frm_hdr_vld | input | 1 | Frame header present this cycle |
| frm_dedicated | input | 1 | Current slot has a dedicated buffer |
| frm_accept | input | 1 | Filter path accepts the frame |
| frm_hdr | input | DATA_W | Header word |
| frm_pl_vld | input | 1 | Payload word present this cycle |
| frm_pl_data | input | DATA_W | Payload word |
| frm_end | input | 1 | Frame finished; status valid |
| frm_valid | input | 1 | Frame received without error |
| frm_null | input | 1 | Frame is a null frame |
| frm_status | input | DATA_W | Slot status word |
| pop_req | input | 1 | Reader removed one entry |
| mem_we | output | 1 | Memory write command valid |
| mem_kind | output | 2 | 0 header, 1 payload, 2 status |
| mem_slot | output | IDX_W | Physical header slot |
| mem_off | output | OFF_W | Payload word offset |
| mem_wdata | output | DATA_W | Data to write |
| fill_lvl | output | IDX_W | Committed entries held |
| fifo_full | output | 1 | Fill level equals depth |

## Verification
A table of frames covers each path: a plain commit, a dedicated slot, filter rejection, an invalid frame, a null frame, a frame longer than the entry, a commit that fills and wraps the FIFO, and an accepted frame refused because the FIFO is full. The invalid and null cases each reuse the slot. This separates "written but not committed" from "never written" and from "committed". Directed tests then drive a pop alone, a pop during a commit, a pop at zero, a configuration write outside the configuration state (seen through the next header's slot), and the clearing on entry to the configuration state followed by a new layout.

// File: rtl/rxfifo_pkg.sv
package rxfifo_pkg;
  typedef enum logic [1:0] {
    WK_HDR  = 2'd0,
    WK_DATA = 2'd1,
    WK_STAT = 2'd2,
    WK_NONE = 2'd3
  } wkind_t;
endpackage

// File: rtl/rxfifo_cfg.sv
module rxfifo_cfg #(
  parameter int IDX_W     = 7,
  parameter int OFF_W     = 8,
  parameter int DEF_DEPTH = 4,
  parameter int DEF_SIZE  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_mode,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_start,
  input  logic [IDX_W-1:0] cfg_depth,
  input  logic [OFF_W-1:0] cfg_size,
  output logic [IDX_W-1:0] start_q,
  output logic [IDX_W-1:0] depth_q,
  output logic [OFF_W-1:0] size_q,
  output logic             cfg_enter
);
  logic mode_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      depth_q <= IDX_W'(DEF_DEPTH);
      size_q  <= OFF_W'(DEF_SIZE);
      mode_d  <= 1'b0;
    end else begin
      mode_d <= cfg_mode;
      if (cfg_mode && cfg_we) begin
        start_q <= cfg_start;
        depth_q <= cfg_depth;
        size_q  <= cfg_size;
      end
    end
  end

  assign cfg_enter = cfg_mode && !mode_d;
endmodule

// File: rtl/rxfifo_track.sv
module rxfifo_track #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             commit,
  input  logic             pop,
  input  logic [IDX_W-1:0] depth,
  output logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] level
);
  logic [IDX_W-1:0] idx_inc;
  logic             pop_ok;

  assign idx_inc = IDX_W'(wr_idx + 1'b1);
  assign pop_ok  = pop && (level != '0);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wr_idx <= '0;
      level  <= '0;
    end else begin
      if (commit) wr_idx <= (idx_inc == depth) ? '0 : idx_inc;
      case ({commit, pop_ok})
        2'b10:   level <= IDX_W'(level + 1'b1);
        2'b01:   level <= IDX_W'(level - 1'b1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/rxfifo_seq.sv
module rxfifo_seq
  import rxfifo_pkg::*;
#(
  parameter int IDX_W  = 7,
  parameter int OFF_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_mode,
  input  logic              full,
  input  logic [IDX_W-1:0]  slot,
  input  logic [OFF_W-1:0]  size,
  input  logic              hdr_vld,
  input  logic              dedicated,
  input  logic              accept,
  input  logic [DATA_W-1:0] hdr,
  input  logic              pl_vld,
  input  logic [DATA_W-1:0] pl_data,
  input  logic              fin,
  input  logic              valid,
  input  logic              is_null,
  input  logic [DATA_W-1:0] status,
  output logic              commit,
  output logic              we,
  output wkind_t            kind,
  output logic [IDX_W-1:0]  wslot,
  output logic [OFF_W-1:0]  woff,
  output logic [DATA_W-1:0] wdata
);
  logic             active;
  logic [OFF_W-1:0] cnt;
  logic             take;

  assign take   = hdr_vld && !dedicated && accept && !full && !cfg_mode;
  assign commit = fin && active && valid && !is_null && !cfg_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      we     <= 1'b0;
      kind   <= WK_NONE;
      wslot  <= '0;
      woff   <= '0;
      wdata  <= '0;
      active <= 1'b0;
      cnt    <= '0;
    end else begin
      we   <= 1'b0;
      kind <= WK_NONE;
      if (hdr_vld) begin
        active <= take;
        cnt    <= '0;
        if (take) begin
          we    <= 1'b1;
          kind  <= WK_HDR;
          wslot <= slot;
          woff  <= '0;
          wdata <= hdr;
        end
      end else if (pl_vld && active) begin
        if (cnt < size) begin
          we    <= 1'b1;
          kind  <= WK_DATA;
          wslot <= slot;
          woff  <= cnt;
          wdata <= pl_data;
          cnt   <= OFF_W'(cnt + 1'b1);
        end
      end else if (fin && active) begin
        active <= 1'b0;
        if (commit) begin
          we    <= 1'b1;
          kind  <= WK_STAT;
          wslot <= slot;
          woff  <= '0;
          wdata <= status;
        end
      end
      if (cfg_mode) active <= 1'b0;
    end
  end
endmodule

// File: rtl/rxfifo_wr_mgr.sv
module rxfifo_wr_mgr
  import rxfifo_pkg::*;
#(
  parameter int IDX_W     = 7,
  parameter int OFF_W     = 8,
  parameter int DATA_W    = 16,
  parameter int DEF_DEPTH = 4,
  parameter int DEF_SIZE  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_mode,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_start,
  input  logic [IDX_W-1:0]  cfg_depth,
  input  logic [OFF_W-1:0]  cfg_size,
  input  logic              frm_hdr_vld,
  input  logic              frm_dedicated,
  input  logic              frm_accept,
  input  logic [DATA_W-1:0] frm_hdr,
  input  logic              frm_pl_vld,
  input  logic [DATA_W-1:0] frm_pl_data,
  input  logic              frm_end,
  input  logic              frm_valid,
  input  logic              frm_null,
  input  logic [DATA_W-1:0] frm_status,
  input  logic              pop_req,
  output logic              mem_we,
  output logic [1:0]        mem_kind,
  output logic [IDX_W-1:0]  mem_slot,
  output logic [OFF_W-1:0]  mem_off,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [IDX_W-1:0]  fill_lvl,
  output logic              fifo_full
);
  logic [IDX_W-1:0] start_q, depth_q, wr_idx, level, slot;
  logic [OFF_W-1:0] size_q;
  logic             cfg_enter, commit;
  wkind_t           kind;

  rxfifo_cfg #(.IDX_W(IDX_W), .OFF_W(OFF_W), .DEF_DEPTH(DEF_DEPTH), .DEF_SIZE(DEF_SIZE)) u_cfg (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_we(cfg_we),
    .cfg_start(cfg_start), .cfg_depth(cfg_depth), .cfg_size(cfg_size),
    .start_q(start_q), .depth_q(depth_q), .size_q(size_q), .cfg_enter(cfg_enter)
  );

  rxfifo_track #(.IDX_W(IDX_W)) u_track (
    .clk(clk), .rst(rst), .clear(cfg_enter), .commit(commit), .pop(pop_req),
    .depth(depth_q), .wr_idx(wr_idx), .level(level)
  );

  assign slot      = IDX_W'(start_q + wr_idx);
  assign fill_lvl  = level;
  assign fifo_full = (level == depth_q);

  rxfifo_seq #(.IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .full(fifo_full), .slot(slot), .size(size_q),
    .hdr_vld(frm_hdr_vld), .dedicated(frm_dedicated), .accept(frm_accept), .hdr(frm_hdr),
    .pl_vld(frm_pl_vld), .pl_data(frm_pl_data), .fin(frm_end), .valid(frm_valid),
    .is_null(frm_null), .status(frm_status), .commit(commit), .we(mem_we), .kind(kind),
    .wslot(mem_slot), .woff(mem_off), .wdata(mem_wdata)
  );

  assign mem_kind = kind;
endmodule

// File: rtl/rxfifo_wr_mgr_chk.sv
module rxfifo_wr_mgr_chk #(
  parameter int IDX_W = 7,
  parameter int OFF_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_mode,
  input logic             frm_hdr_vld,
  input logic             frm_dedicated,
  input logic             frm_accept,
  input logic             pop_req,
  input logic             mem_we,
  input logic [1:0]       mem_kind,
  input logic [OFF_W-1:0] mem_off,
  input logic [IDX_W-1:0] fill_lvl,
  input logic             fifo_full,
  input logic [IDX_W-1:0] depth_q,
  input logic [OFF_W-1:0] size_q
);
  AST_NO_WRITE_DEDICATED: assert property (@(posedge clk) disable iff (rst)
    (frm_hdr_vld && frm_dedicated) |=> !mem_we); // R1

  AST_NO_WRITE_REJECT: assert property (@(posedge clk) disable iff (rst)
    (frm_hdr_vld && (!frm_accept || fifo_full)) |=> !mem_we); // R2

  AST_HDR_WRITE: assert property (@(posedge clk) disable iff (rst)
    (frm_hdr_vld && !frm_dedicated && frm_accept && !fifo_full && !cfg_mode)
      |=> (mem_we && mem_kind == 2'd0 && mem_off == '0)); // R3

  AST_DATA_IN_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_kind == 2'd1) |-> (mem_off < size_q)); // R4

  AST_COMMIT_COUNT: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_kind == 2'd2 && !$past(pop_req) && $past(!rst))
      |-> (fill_lvl == IDX_W'($past(fill_lvl) + 1'b1))); // R5

  AST_POP_DEC: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(pop_req && fill_lvl != '0 && !cfg_mode) && !(mem_we && mem_kind == 2'd2))
      |-> (fill_lvl == IDX_W'($past(fill_lvl) - 1'b1))); // R9

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
    !cfg_mode |=> ($stable(depth_q) && $stable(size_q))); // R10
endmodule

bind rxfifo_wr_mgr rxfifo_wr_mgr_chk #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .frm_hdr_vld(frm_hdr_vld),
  .frm_dedicated(frm_dedicated), .frm_accept(frm_accept), .pop_req(pop_req),
  .mem_we(mem_we), .mem_kind(mem_kind), .mem_off(mem_off), .fill_lvl(fill_lvl),
  .fifo_full(fifo_full), .depth_q(depth_q), .size_q(size_q)
);

// File: tb/rxfifo_wr_mgr_bench.sv
module rxfifo_wr_mgr_bench;
  localparam int IDX_W = 7, OFF_W = 8, DATA_W = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_mode = 0, cfg_we = 0;
  logic [IDX_W-1:0] cfg_start = '0, cfg_depth = '0;
  logic [OFF_W-1:0] cfg_size = '0;
  logic frm_hdr_vld = 0, frm_dedicated = 0, frm_accept = 0, frm_pl_vld = 0;
  logic frm_end = 0, frm_valid = 0, frm_null = 0, pop_req = 0;
  logic [DATA_W-1:0] frm_hdr = '0, frm_pl_data = '0, frm_status = '0;
  logic mem_we, fifo_full;
  logic [1:0] mem_kind;
  logic [IDX_W-1:0] mem_slot, fill_lvl;
  logic [OFF_W-1:0] mem_off;
  logic [DATA_W-1:0] mem_wdata;

  int checks = 0, failures = 0;
  int m_start = 0, m_depth = 4, m_size = 4, m_idx = 0, m_lvl = 0;

  always #10 clk = ~clk;

  rxfifo_wr_mgr u_rxfifo_wr_mgr (.*);

  // vector: {dedicated, accept, valid, null, payload words[1:0], header[15:0]}
  localparam logic [21:0] VEC [8] = '{
    {1'b0, 1'b1, 1'b1, 1'b0, 2'd2, 16'hA001},  // commit
    {1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 16'hA002},  // dedicated slot
    {1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 16'hA003},  // filter reject
    {1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 16'hA004},  // invalid
    {1'b0, 1'b1, 1'b1, 1'b1, 2'd1, 16'hA005},  // null
    {1'b0, 1'b1, 1'b1, 1'b0, 2'd3, 16'hA006},  // too long
    {1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 16'hA007},  // fills, wraps
    {1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 16'hA008}   // full
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input bit ded, input bit acc, input bit v, input bit n,
                      input int np, input logic [15:0] hv, input bit pop_end);
    bit take, com;
    take = !ded && acc && (m_lvl != m_depth) && !cfg_mode;
    @(negedge clk);
    frm_hdr_vld = 1; frm_dedicated = ded; frm_accept = acc; frm_hdr = hv;
    @(negedge clk);
    frm_hdr_vld = 0;
    chk(mem_we == take, ded ? "R1" : (cfg_mode ? "R11" : (take ? "R3" : "R2")), mem_we, take);
    if (take) begin
      chk(mem_kind == 0 && mem_off == 0 && mem_wdata == hv, "R3", mem_wdata, hv);
      chk(mem_slot == IDX_W'(m_start + m_idx), "R3", mem_slot, m_start + m_idx);
    end
    for (int i = 0; i < np; i++) begin
      frm_pl_vld = 1; frm_pl_data = hv + 16'(i + 1);
      @(negedge clk);
      frm_pl_vld = 0;
      chk(mem_we == (take && i < m_size), "R4", mem_we, take && i < m_size);
      if (take && i < m_size)
        chk(mem_kind == 1 && mem_off == OFF_W'(i), "R4", mem_off, i);
    end
    frm_end = 1; frm_valid = v; frm_null = n; frm_status = ~hv; pop_req = pop_end;
    @(negedge clk);
    frm_end = 0; pop_req = 0;
    com = take && v && !n;
    chk(mem_we == com, com ? "R5" : "R6", mem_we, com);
    if (com) begin
      chk(mem_kind == 2 && mem_wdata == ~hv, "R5", mem_wdata, ~hv);
      m_idx = (m_idx + 1 == m_depth) ? 0 : m_idx + 1;
      m_lvl++;
    end
    if (pop_end && m_lvl > 0 && !(com && m_lvl == 0)) m_lvl = com ? m_lvl - 1 : m_lvl - 1;
    chk(fill_lvl == IDX_W'(m_lvl), pop_end ? "R9" : (com ? "R5" : "R6"), fill_lvl, m_lvl);
    chk(fifo_full == (m_lvl == m_depth), "R8", fifo_full, m_lvl == m_depth);
  endtask

  task automatic config_write(input int s, input int d, input int z);
    cfg_we = 1; cfg_start = IDX_W'(s); cfg_depth = IDX_W'(d); cfg_size = OFF_W'(z);
    @(negedge clk);
    cfg_we = 0;
    if (cfg_mode) begin m_start = s; m_depth = d; m_size = z; end
  endtask

  task automatic pop_one;
    pop_req = 1;
    @(negedge clk);
    pop_req = 0;
    if (m_lvl > 0) m_lvl--;
    chk(fill_lvl == IDX_W'(m_lvl), "R9", fill_lvl, m_lvl);
    chk(fifo_full == (m_lvl == m_depth), "R8", fifo_full, m_lvl == m_depth);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    chk(mem_we == 0, "R12", mem_we, 0);
    chk(fill_lvl == 0 && fifo_full == 0, "R12", fill_lvl, 0);

    // layout: start 10, depth 3, size 2
    cfg_mode = 1; @(negedge clk);
    config_write(10, 3, 2);
    cfg_mode = 0; @(negedge clk);

    for (int k = 0; k < 8; k++)
      send(VEC[k][21], VEC[k][20], VEC[k][19], VEC[k][18], int'(VEC[k][17:16]), VEC[k][15:0], 0);
    // after table: level 3, index wrapped to 0 (R7)

    pop_one;                                   // R9 level 2
    send(0, 1, 1, 0, 1, 16'hB001, 1);          // R9 commit+pop; slot 10 checks R7
    pop_one; pop_one; pop_one;                 // R9 down to zero, stays zero

    config_write(40, 5, 6);                    // R10 ignored outside config
    send(0, 1, 1, 0, 2, 16'hB002, 0);          // slot must still be 10+1

    cfg_mode = 1; @(negedge clk);
    m_idx = 0; m_lvl = 0;
    chk(fill_lvl == 0, "R11", fill_lvl, 0);
    config_write(20, 2, 1);
    send(0, 1, 1, 0, 1, 16'hB003, 0);          // R11 no write in config state
    cfg_mode = 0; @(negedge clk);
    send(0, 1, 1, 0, 2, 16'hB004, 0);          // slot 20, R10 new layout
    send(0, 1, 1, 0, 1, 16'hB005, 0);          // slot 21, full, wrap R7
    send(0, 1, 1, 0, 1, 16'hB006, 0);          // R2 full

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule